// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in/first-out buffer from a ring of identical storage slices. No slice knows a shared address. Instead, each slice may hold a write token and a read token. A single shared write strobe and a single shared read strobe are broadcast to all slices. Only the slice that holds the write token stores the incoming word, and only the slice that holds the read token supplies the outgoing word. When the token holder uses its last physical location, it raises a one-cycle hand-off pulse. That pulse moves the token to the next slice in the ring, and the last slice hands back to the first.

After reset, a per-slice first-load input picks the slice that starts with both tokens. Every pointer starts at location zero. The two tokens then travel on their own, so the write token can run several slices ahead of the read token. The composite empty and full flags combine the flags of all slices. As a result, the ring behaves like a single FIFO of depth NUM_SLICES × SLICE_DEPTH. Read data comes back one clock after the read is accepted, and the design selects it from the slice that held the read token at that moment. The hand-off pulses are also driven out of the block, so the position of each token can be observed from outside.

Top module: `tok_fifo_chain`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the slice whose `firstLoadN` bit is 0 takes both tokens. The next words go into that slice. After reset, `emptyN` is 0, `fullN` is 1 and `rdValid` is 0.
- R2: Words come out of `rdData` in the same order in which they were accepted, across all slice boundaries and wrap-arounds.
- R3: An accepted write into the last location (SLICE_DEPTH-1) of the write-token slice drives bit i of `wrPassOut` to 1 in that same cycle, where i is the index of that slice. The write token then moves to slice (i+1) mod NUM_SLICES. That slice stores the next word at its location 0.
- R4: An accepted read from the last location of the read-token slice drives bit i of `rdPassOut` to 1 in that same cycle. The read token then moves to slice (i+1) mod NUM_SLICES.
- R5: `fullN` is 0 exactly when NUM_SLICES × SLICE_DEPTH words are stored. While `fullN` is 0, a write has no effect.
- R6: `emptyN` is 0 exactly when no word is stored. While `emptyN` is 0, a read has no effect: `rdValid` stays 0 and no word is lost.
- R7: A read and a write in the same cycle are both accepted when the FIFO is neither empty nor full.
- R8: A read is accepted in the cycle where `rdEn` is 1 and `emptyN` is 1. `rdValid` is then 1 for exactly the following cycle, and `rdData` holds that word. In all other cycles `rdValid` is 0.
- R9: A reset taken in the middle of operation discards all stored words. It returns every pointer to location 0, so the first hand-off pulse after reset again comes after SLICE_DEPTH writes.
- R10: Under long random mixes of reads and writes, which include many full and empty boundaries and several complete trips of both tokens around the ring, the output sequence matches an ideal FIFO of the same total depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| firstLoadN | input | NUM_SLICES | Exactly one bit is 0; that bit marks the slice that owns both tokens after reset |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to be written |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Word read out, valid while rdValid is 1 |
| rdValid | output | 1 | rdData holds the word of the read accepted in the previous cycle |
| emptyN | output | 1 | Composite empty flag, active low |
| fullN | output | 1 | Composite full flag, active low |
| wrPassOut | output | NUM_SLICES | Write-token hand-off pulses, one bit per slice |
| rdPassOut | output | NUM_SLICES | Read-token hand-off pulses, one bit per slice |

## Verification
The composite flags are registered state, so they describe the FIFO as it stands at the start of a cycle. The hand-off pulses are combinational from the strobes in the same cycle. The bench therefore drives requests on the falling edge and checks the flags and pulses 1 ns later, within the same cycle. Read data and `rdValid` appear one rising edge after acceptance, so they are checked 1 ns after that edge. The bench's expected values come from a queue model and from two slice/location counters that it updates only after each edge.

// File: rtl/tok_fifo_chain_pkg.sv
package tok_fifo_chain_pkg;

  // Strobes sent from a slice's control to its storage.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } slice_stb_t;

  function automatic int unsigned ptrWidth(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tok_slice_ctrl.sv
module tok_slice_ctrl
  import tok_fifo_chain_pkg::*;
#(
  parameter int unsigned SLICE_DEPTH = 4,
  parameter int unsigned PTR_W       = ptrWidth(SLICE_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             firstLoadN,
  input  logic             wrPassIn,
  input  logic             rdPassIn,
  input  logic             wrAcc,
  input  logic             rdAcc,
  output logic             wrTok,
  output logic             rdTok,
  output logic             wrPass,
  output logic             rdPass,
  output slice_stb_t       stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             sliceEmptyN,
  output logic             sliceFullN
);

  localparam int unsigned CNT_W = $clog2(SLICE_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_LOC = PTR_W'(SLICE_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLICE_DEPTH);

  logic [CNT_W-1:0] count;
  logic             wrAtLast;
  logic             rdAtLast;

  assign wrAtLast = (wrPtr == LAST_LOC);
  assign rdAtLast = (rdPtr == LAST_LOC);

  always_comb begin
    stb.wrStb = wrTok & wrAcc;
    stb.rdStb = rdTok & rdAcc;
  end

  assign wrPass = stb.wrStb & wrAtLast;
  assign rdPass = stb.rdStb & rdAtLast;

  assign sliceEmptyN = (count != '0);
  assign sliceFullN  = (count != CNT_FULL);

  // Token ownership: an incoming hand-off has priority, so that a ring of
  // one slice keeps its own tokens.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrTok <= ~firstLoadN;
      rdTok <= ~firstLoadN;
    end else begin
      if (wrPassIn)    wrTok <= 1'b1;
      else if (wrPass) wrTok <= 1'b0;
      if (rdPassIn)    rdTok <= 1'b1;
      else if (rdPass) rdTok <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrStb) wrPtr <= wrAtLast ? '0 : wrPtr + 1'b1;
      if (stb.rdStb) rdPtr <= rdAtLast ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({stb.wrStb, stb.rdStb})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tok_slice_store.sv
module tok_slice_store
  import tok_fifo_chain_pkg::*;
#(
  parameter int unsigned DATA_W      = 9,
  parameter int unsigned SLICE_DEPTH = 4,
  parameter int unsigned PTR_W       = ptrWidth(SLICE_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  slice_stb_t        stb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdQ
);

  logic [DATA_W-1:0] mem [SLICE_DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (stb.rdStb) rdQ <= mem[rdPtr];
  end

endmodule

// File: rtl/tok_fifo_chain.sv
module tok_fifo_chain
  import tok_fifo_chain_pkg::*;
#(
  parameter int unsigned NUM_SLICES  = 3,
  parameter int unsigned SLICE_DEPTH = 4,
  parameter int unsigned DATA_W      = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SLICES-1:0] firstLoadN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  emptyN,
  output logic                  fullN,
  output logic [NUM_SLICES-1:0] wrPassOut,
  output logic [NUM_SLICES-1:0] rdPassOut
);

  localparam int unsigned PTR_W = ptrWidth(SLICE_DEPTH);

  logic [NUM_SLICES-1:0] wrTok;
  logic [NUM_SLICES-1:0] rdTok;
  logic [NUM_SLICES-1:0] wrPass;
  logic [NUM_SLICES-1:0] rdPass;
  logic [NUM_SLICES-1:0] sliceEmptyN;
  logic [NUM_SLICES-1:0] sliceFullN;
  logic [NUM_SLICES-1:0] rdSel;
  logic [DATA_W-1:0]     sliceQ [NUM_SLICES];
  logic                  wrAcc;
  logic                  rdAcc;

  // Active-low flags: the composite is asserted only when every slice agrees.
  assign emptyN = |sliceEmptyN;
  assign fullN  = |sliceFullN;
  assign wrAcc  = wrEn & fullN;
  assign rdAcc  = rdEn & emptyN;

  assign wrPassOut = wrPass;
  assign rdPassOut = rdPass;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int unsigned PREV = (i == 0) ? NUM_SLICES - 1 : i - 1;

    slice_stb_t       stb;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;

    tok_slice_ctrl #(
      .SLICE_DEPTH(SLICE_DEPTH),
      .PTR_W      (PTR_W)
    ) u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .firstLoadN (firstLoadN[i]),
      .wrPassIn   (wrPass[PREV]),
      .rdPassIn   (rdPass[PREV]),
      .wrAcc      (wrAcc),
      .rdAcc      (rdAcc),
      .wrTok      (wrTok[i]),
      .rdTok      (rdTok[i]),
      .wrPass     (wrPass[i]),
      .rdPass     (rdPass[i]),
      .stb        (stb),
      .wrPtr      (wrPtr),
      .rdPtr      (rdPtr),
      .sliceEmptyN(sliceEmptyN[i]),
      .sliceFullN (sliceFullN[i])
    );

    tok_slice_store #(
      .DATA_W     (DATA_W),
      .SLICE_DEPTH(SLICE_DEPTH),
      .PTR_W      (PTR_W)
    ) u_store (
      .clk   (clk),
      .rstN  (rstN),
      .stb   (stb),
      .wrPtr (wrPtr),
      .rdPtr (rdPtr),
      .wrData(wrData),
      .rdQ   (sliceQ[i])
    );
  end

  // Remember which slice answered the accepted read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSel   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdSel   <= rdTok & {NUM_SLICES{rdAcc}};
      rdValid <= rdAcc;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (rdSel[i]) rdData |= sliceQ[i];
    end
  end

endmodule

// File: rtl/tok_fifo_chain_chk.sv
module tok_fifo_chain_chk #(
  parameter int unsigned NUM_SLICES = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic                  emptyN,
  input logic                  fullN,
  input logic                  rdValid,
  input logic [NUM_SLICES-1:0] wrTok,
  input logic [NUM_SLICES-1:0] rdTok,
  input logic [NUM_SLICES-1:0] wrPass,
  input logic [NUM_SLICES-1:0] rdPass
);

  // R1 / R3: exactly one slice owns the write token.
  p_one_wr_token_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wrTok) == 1);

  // R1 / R4: exactly one slice owns the read token.
  p_one_rd_token_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rdTok) == 1);

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_ring
    localparam int unsigned NEXT = (i + 1) % NUM_SLICES;

    p_wr_handoff_r3: assert property (@(posedge clk) disable iff (!rstN)
      wrPass[i] |=> wrTok[NEXT]);

    p_rd_handoff_r4: assert property (@(posedge clk) disable iff (!rstN)
      rdPass[i] |=> rdTok[NEXT]);
  end

  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN && !rdEn) |=> !fullN);

  p_empty_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!emptyN && !wrEn) |=> (!emptyN && !rdValid));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!emptyN && !fullN));

  p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && emptyN) |=> rdValid);

  p_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && emptyN) |=> !rdValid);

endmodule

bind tok_fifo_chain tok_fifo_chain_chk #(
  .NUM_SLICES(NUM_SLICES)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .emptyN (emptyN),
  .fullN  (fullN),
  .rdValid(rdValid),
  .wrTok  (wrTok),
  .rdTok  (rdTok),
  .wrPass (wrPass),
  .rdPass (rdPass)
);

// File: tb/tok_fifo_chain_bench.sv
module tok_fifo_chain_bench;

  localparam int N   = 3;
  localparam int D   = 4;
  localparam int W   = 9;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] firstLoadN = 3'b110;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         rdEn = 1'b0;
  logic [W-1:0] rdData;
  logic         rdValid;
  logic         emptyN;
  logic         fullN;
  logic [N-1:0] wrPassOut;
  logic [N-1:0] rdPassOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] model [$];
  int wrSlice, wrLoc, rdSlice, rdLoc;
  int popped;
  bit lastRdAcc;

  always #5 clk = ~clk;

  tok_fifo_chain #(.NUM_SLICES(N), .SLICE_DEPTH(D), .DATA_W(W)) u_tok_fifo_chain (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .emptyN(emptyN), .fullN(fullN),
    .wrPassOut(wrPassOut), .rdPassOut(rdPassOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int fl);
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    firstLoadN = ~(N'(1) << fl);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    model.delete();
    wrSlice = fl; rdSlice = fl; wrLoc = 0; rdLoc = 0;
    lastRdAcc = 1'b0;
  endtask

  // One clock of stimulus with every check that cycle calls for.
  task automatic cycle(input logic we, input logic [W-1:0] wd, input logic re);
    int sz;
    bit accW, accR;
    logic [W-1:0] expD;
    logic [31:0] expWp, expRp;
    @(negedge clk);
    wrEn = we; wrData = wd; rdEn = re;
    #1;
    sz = model.size();
    accW = we && (sz < CAP);
    accR = re && (sz > 0);
    check("R5 fullN", 32'(fullN), 32'(sz < CAP));
    check("R6 emptyN", 32'(emptyN), 32'(sz > 0));
    expWp = (accW && wrLoc == D - 1) ? (32'd1 << wrSlice) : 32'd0;
    expRp = (accR && rdLoc == D - 1) ? (32'd1 << rdSlice) : 32'd0;
    check("R3 / R1 wrPassOut", 32'(wrPassOut), expWp);
    check("R4 rdPassOut", 32'(rdPassOut), expRp);
    expD = '0;
    if (accR) expD = model.pop_front();
    if (accW) model.push_back(wd);
    @(posedge clk);
    #1;
    check("R8 rdValid", 32'(rdValid), 32'(accR));
    if (accR) begin
      check("R2 rdData", 32'(rdData), 32'(expD));
      popped++;
    end
    if (accW) begin
      wrLoc++;
      if (wrLoc == D) begin wrLoc = 0; wrSlice = (wrSlice + 1) % N; end
    end
    if (accR) begin
      rdLoc++;
      if (rdLoc == D) begin rdLoc = 0; rdSlice = (rdSlice + 1) % N; end
    end
    lastRdAcc = accR;
  endtask

  task automatic test_reset();
    do_reset(0);
    #1;
    check("R1 emptyN after reset", 32'(emptyN), 32'd0);
    check("R1 fullN after reset", 32'(fullN), 32'd1);
    check("R1 rdValid after reset", 32'(rdValid), 32'd0);
    check("R1 wrPassOut idle", 32'(wrPassOut), 32'd0);
  endtask

  // R5, R3, R4, R2: fill past capacity, then drain past empty.
  task automatic test_fill_drain();
    do_reset(0);
    for (int i = 0; i < CAP + 2; i++) cycle(1'b1, W'(9'h100 + i), 1'b0);
    check("R5 stored count at full", 32'(model.size()), 32'(CAP));
    popped = 0;
    for (int i = 0; i < CAP + 2; i++) cycle(1'b0, '0, 1'b1);
    check("R5 extra writes dropped", 32'(popped), 32'(CAP));
  endtask

  // R6: reads on an empty FIFO do nothing.
  task automatic test_empty_read();
    do_reset(1);
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, 1'b1);
    check("R6 nothing stored", 32'(model.size()), 32'd0);
    cycle(1'b1, 9'h0a5, 1'b0);
    cycle(1'b0, '0, 1'b1);
    check("R6 single word returned", 32'(rdData), 32'h0a5);
  endtask

  // R7: read and write in the same cycle.
  task automatic test_simul();
    do_reset(0);
    for (int i = 0; i < 5; i++) cycle(1'b1, W'(9'h040 + i), 1'b0);
    for (int i = 0; i < 10; i++) begin
      cycle(1'b1, W'(9'h080 + i), 1'b1);
      check("R7 read accepted with write", 32'(lastRdAcc), 32'd1);
    end
    check("R7 occupancy kept", 32'(model.size()), 32'd5);
    for (int i = 0; i < 6; i++) cycle(1'b0, '0, 1'b1);
  endtask

  // R9: reset mid-stream clears contents and pointers.
  task automatic test_midreset();
    do_reset(0);
    for (int i = 0; i < 7; i++) cycle(1'b1, W'(9'h020 + i), 1'b0);
    cycle(1'b0, '0, 1'b1);
    do_reset(2);
    #1;
    check("R9 emptyN after reset", 32'(emptyN), 32'd0);
    check("R9 rdValid after reset", 32'(rdValid), 32'd0);
    for (int i = 0; i < D + 1; i++) cycle(1'b1, W'(9'h150 + i), 1'b0);
    check("R9 write token moved once", 32'(wrSlice), 32'd0);
    for (int i = 0; i < D + 2; i++) cycle(1'b0, '0, 1'b1);
  endtask

  // R10: random mix with biased phases for wrap-arounds and boundaries.
  task automatic test_random();
    void'($urandom(32'h5eed));
    do_reset(1);
    for (int round = 0; round < 5; round++) begin
      for (int c = 0; c < 250; c++)
        cycle(($urandom_range(0, 99) < 75), W'($urandom), ($urandom_range(0, 99) < 30));
      for (int c = 0; c < 250; c++)
        cycle(($urandom_range(0, 99) < 30), W'($urandom), ($urandom_range(0, 99) < 75));
    end
    while (model.size() > 0) cycle(1'b0, '0, 1'b1);
    check("R10 drained", 32'(emptyN), 32'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    test_reset();
    test_fill_drain();
    test_empty_read();
    test_simul();
    test_midreset();
    test_random();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule